// File: doc/BRIEF.md
# Narrow-Memory Bus Sizing Bridge

This block sits between a 32-bit processor bus and a memory region whose data path is 32, 16 or 8 bits wide. The processor presents a word address, four active-low byte enables, write data, and a read or write strobe. A region-width code, decoded elsewhere from the address, tells the bridge how wide the addressed memory is.

For a narrow region, the bridge turns the byte enables into the low address bits and byte strobes that the narrow memory needs. It moves the selected write bytes down onto the memory's low data lines. It spreads the returned read data across the processor lanes where the processor expects it. It also sends back an active-low size indication that says the region is narrow.

Each request produces exactly one memory cycle. Breaking a wide request into several narrow cycles is left to the requester. If a request enables more bytes than the narrow memory can carry, only the lowest enabled byte and its partner bytes in the same narrow beat are served.

Top module: `bus_size_bridge`

## Requirements
- R1: A request is accepted at a rising clock edge where `req_rd` or `req_wr` is high. In the cycle after that edge, the memory-side outputs of the request are presented. Exactly one memory strobe pulses high for that one cycle: `mem_rd` if `req_rd` was high (read wins when both are high), otherwise `mem_wr`.
- R2: Region code 0 (32-bit) and code 3 (treated as 32-bit) behave the same. `mem_addr` is the word address with both low bits zero, `mem_be_n` equals `req_be_n`, and `mem_bhe_n` and `mem_ble_n` are both high.
- R3: `size16_n` is low only in the presented cycle of a request to region code 1 (16-bit). `size8_n` is low only in the presented cycle of a request to region code 2 (8-bit). Both are high for 32-bit regions and when idle.
- R4: For a narrow region, `mem_addr[1]` is high exactly when byte 0 and byte 1 are both disabled.
- R5: For a narrow region, `mem_addr[0]` is high when the lowest enabled byte has an odd index. `mem_ble_n` equals `mem_addr[0]`, and `mem_be_n` is all ones.
- R6: For a 16-bit region, `mem_bhe_n` is low when the odd byte of the selected half-word is enabled: byte 3 if `mem_addr[1]` is high, otherwise byte 1. For an 8-bit region, `mem_bhe_n` is high.
- R7: On a 16-bit write, `mem_wdata[15:0]` carries write bits [31:16] when `mem_addr[1]` is high and bits [15:0] otherwise. Bits [31:16] pass through unchanged.
- R8: On an 8-bit write, `mem_wdata[7:0]` carries the write byte at lane index {`mem_addr[1]`,`mem_addr[0]`}. Bits [31:8] pass through unchanged.
- R9: `mem_rdata` is sampled at the edge that ends the presented cycle. `rsp_done` is high for exactly the next cycle. On a read, `rsp_rdata` then holds the steered data: unchanged for 32-bit, the low half-word copied into both halves for 16-bit, and the low byte copied into all four lanes for 8-bit.
- R10: A request with `req_be_n` = 4'b1111 is a no-op. It raises no memory strobe, leaves `mem_wdata` and `rsp_rdata` unchanged, and still produces the `rsp_done` pulse.
- R11: While `rst_n` is low at a clock edge, the bridge returns to idle. Strobes and `rsp_done` are low. Size, byte and half-word enables are high. Address and data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_addr | input | 30 | Word address, byte address bits [31:2] |
| req_be_n | input | 4 | Active-low byte enables, bit i selects byte i |
| req_wdata | input | 32 | Processor write data |
| req_rd | input | 1 | Read request strobe |
| req_wr | input | 1 | Write request strobe |
| region_width | input | 2 | 0: 32-bit, 1: 16-bit, 2: 8-bit, 3: treated as 32-bit |
| mem_addr | output | 32 | Byte address to memory, low bits decoded for narrow regions |
| mem_be_n | output | 4 | Active-low byte enables for a 32-bit region |
| mem_bhe_n | output | 1 | Active-low high-byte enable for a 16-bit region |
| mem_ble_n | output | 1 | Active-low low-byte enable, equal to address bit 0 for narrow regions |
| mem_rd | output | 1 | One-cycle memory read strobe |
| mem_wr | output | 1 | One-cycle memory write strobe |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Memory read data, valid in the strobe cycle |
| size8_n | output | 1 | Active-low 8-bit region indication |
| size16_n | output | 1 | Active-low 16-bit region indication |
| rsp_rdata | output | 32 | Read data steered onto the processor lanes |
| rsp_done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a no-op that arrives after an earlier access has already loaded `rsp_rdata` and `mem_wdata`. Only then can the bench show that the no-op leaves both values untouched while still producing `rsp_done`. The bench first runs a real read and a real write with known patterns. It then sends all-disabled byte enables with a different memory pattern on `mem_rdata` and different write data, and compares against the values left by the earlier accesses. The vector table also covers byte-enable patterns that span both half-words, such as bytes 0 and 3 together or bytes 1 and 2 together. These cases separate the lowest-byte rule and the selected-half high-byte rule from simpler decodes.

// File: rtl/bsb_pkg.sv
// Shared widths, region codes and the decoded lane-select record for the
// bus sizing bridge. Assumes a processor data path made of whole bytes.
package bsb_pkg;
    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int HALF_W = DATA_W / 2;
    localparam int LANES  = DATA_W / BYTE_W;
    localparam int IDX_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        RW_32  = 2'd0,
        RW_16  = 2'd1,
        RW_8   = 2'd2,
        RW_RSV = 2'd3
    } region_w_e;

    typedef struct packed {
        logic [IDX_W-1:0] lane;   // low address bits presented to memory
        logic             noop;   // no byte enabled
        logic             bhe_n;  // high-byte enable, 16-bit region
        logic             ble_n;  // low-byte enable, equals address bit 0
        logic [LANES-1:0] be_n;   // byte enables for a 32-bit region
    } lane_sel_t;
endpackage

// File: rtl/bsb_lane_decode.sv
// Byte-enable decoder. Finds the lowest enabled byte and derives the low
// address bits plus the half-word and byte strobes for the addressed width.
// Assumes four byte lanes; purely combinational.
module bsb_lane_decode
    import bsb_pkg::*;
(
    input  logic [LANES-1:0] be_n,
    input  region_w_e        width,
    output lane_sel_t        sel
);
    logic [LANES-1:0] be;
    logic [IDX_W-1:0] low_idx;
    logic             narrow;
    logic             none_on;

    // Locate the lowest enabled byte lane.
    always_comb begin
        be      = ~be_n;
        low_idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (be[i]) low_idx = IDX_W'(i);
        end
    end

    assign none_on = (be == '0);
    assign narrow  = (width == RW_16) || (width == RW_8);

    // Assemble the strobes that the addressed memory width needs.
    always_comb begin
        sel.noop  = none_on;
        sel.lane  = (narrow && !none_on) ? low_idx : '0;
        sel.ble_n = 1'b1;
        sel.bhe_n = 1'b1;
        sel.be_n  = '1;
        if (!narrow) begin
            sel.be_n = be_n;
        end else if (!none_on) begin
            sel.ble_n = low_idx[0];
            if (width == RW_16) sel.bhe_n = ~be[{low_idx[IDX_W-1], 1'b1}];
        end
    end
endmodule

// File: rtl/bsb_wr_steer.sv
// Write-data steering. Moves the selected half-word or byte onto the low
// memory lanes; lanes that are not steered pass through unchanged.
module bsb_wr_steer
    import bsb_pkg::*;
(
    input  logic [DATA_W-1:0] wdata,
    input  region_w_e         width,
    input  logic [IDX_W-1:0]  lane,
    output logic [DATA_W-1:0] mdata
);
    // Select the source lane for the narrow memory data lines.
    always_comb begin
        mdata = wdata;
        case (width)
            RW_16:   mdata[HALF_W-1:0] = wdata[lane[IDX_W-1]*HALF_W +: HALF_W];
            RW_8:    mdata[BYTE_W-1:0] = wdata[lane*BYTE_W +: BYTE_W];
            default: mdata = wdata;
        endcase
    end
endmodule

// File: rtl/bsb_rd_steer.sv
// Read-data steering. Copies the narrow memory's low lanes onto every
// processor lane they can serve, so the byte lands where it was asked for.
module bsb_rd_steer
    import bsb_pkg::*;
(
    input  logic [DATA_W-1:0] mdata,
    input  region_w_e         width,
    output logic [DATA_W-1:0] rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Choose the memory byte that feeds processor lane g.
        always_comb begin
            case (width)
                RW_8:    rdata[g*BYTE_W +: BYTE_W] = mdata[BYTE_W-1:0];
                RW_16:   rdata[g*BYTE_W +: BYTE_W] = mdata[(g % 2)*BYTE_W +: BYTE_W];
                default: rdata[g*BYTE_W +: BYTE_W] = mdata[g*BYTE_W +: BYTE_W];
            endcase
        end
    end
endmodule

// File: rtl/bus_size_bridge.sv
// Bus sizing bridge between a 32-bit requester and a 32/16/8-bit memory
// region. Registers one narrow memory cycle per request, then registers the
// steered read data with a one-cycle completion pulse. Assumes the memory
// returns read data within the strobe cycle and the region code is stable
// alongside the request strobe.
module bus_size_bridge
    import bsb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-3:0]   req_addr,
    input  logic [LANES-1:0]    req_be_n,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                req_rd,
    input  logic                req_wr,
    input  logic [1:0]          region_width,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [LANES-1:0]    mem_be_n,
    output logic                mem_bhe_n,
    output logic                mem_ble_n,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                size8_n,
    output logic                size16_n,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_done
);
    localparam int WORD_AW = ADDR_W - IDX_W;

    region_w_e         req_w;
    lane_sel_t         sel;
    logic [DATA_W-1:0] wr_steered;
    logic [DATA_W-1:0] rd_steered;
    logic              req_go;
    logic              req_is_wr;

    logic              s1_valid;
    logic              s1_rd;
    logic              s1_noop;
    region_w_e         s1_w;

    assign req_w     = region_w_e'(region_width);
    assign req_go    = req_rd | req_wr;
    assign req_is_wr = req_wr & ~req_rd;

    bsb_lane_decode i_decode (
        .be_n  (req_be_n),
        .width (req_w),
        .sel   (sel)
    );

    bsb_wr_steer i_wr_steer (
        .wdata (req_wdata),
        .width (req_w),
        .lane  (sel.lane),
        .mdata (wr_steered)
    );

    bsb_rd_steer i_rd_steer (
        .mdata (mem_rdata),
        .width (s1_w),
        .rdata (rd_steered)
    );

    // Stage 1: present one memory cycle for each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_rd     <= 1'b0;
            s1_noop   <= 1'b0;
            s1_w      <= RW_32;
            mem_rd    <= 1'b0;
            mem_wr    <= 1'b0;
            mem_addr  <= '0;
            mem_be_n  <= '1;
            mem_bhe_n <= 1'b1;
            mem_ble_n <= 1'b1;
            mem_wdata <= '0;
            size8_n   <= 1'b1;
            size16_n  <= 1'b1;
        end else begin
            s1_valid <= req_go;
            mem_rd   <= req_rd & ~sel.noop;
            mem_wr   <= req_is_wr & ~sel.noop;
            size8_n  <= ~(req_go && req_w == RW_8);
            size16_n <= ~(req_go && req_w == RW_16);
            if (req_go) begin
                s1_rd     <= req_rd;
                s1_noop   <= sel.noop;
                s1_w      <= req_w;
                mem_addr  <= {req_addr[WORD_AW-1:0], sel.lane};
                mem_be_n  <= sel.be_n;
                mem_bhe_n <= sel.bhe_n;
                mem_ble_n <= sel.ble_n;
                if (req_is_wr && !sel.noop) mem_wdata <= wr_steered;
            end
        end
    end

    // Stage 2: capture steered read data and signal completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= s1_valid;
            if (s1_valid && s1_rd && !s1_noop) rsp_rdata <= rd_steered;
        end
    end

    // At most one memory strobe, and only after an accepted request.
    assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}));
    assert_strobe_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> $past(req_go));

    // Size indications are exclusive and quiet when no request came in.
    assert_size_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!size8_n && !size16_n));
    assert_size_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_go) |-> (size8_n && size16_n));

    // A narrow region never drives the wide byte enables.
    assert_narrow_be_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!size8_n || !size16_n) |-> (mem_be_n == '1));

    // Completion follows the presented cycle by exactly one edge.
    assert_done_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |=> rsp_done);

    // All-disabled byte enables never reach the memory.
    assert_noop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_go && req_be_n == '1) |-> (!mem_rd && !mem_wr));
endmodule

// File: tb/test_bus_size_bridge.sv
module test_bus_size_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] req_addr = '0;
    logic [3:0]  req_be_n = 4'hF;
    logic [31:0] req_wdata = '0;
    logic        req_rd = 1'b0;
    logic        req_wr = 1'b0;
    logic [1:0]  region_width = 2'd0;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be_n;
    logic        mem_bhe_n, mem_ble_n, mem_rd, mem_wr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        size8_n, size16_n;
    logic [31:0] rsp_rdata;
    logic        rsp_done;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    bus_size_bridge i_bus_size_bridge (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_be_n(req_be_n),
        .req_wdata(req_wdata), .req_rd(req_rd), .req_wr(req_wr),
        .region_width(region_width), .mem_addr(mem_addr), .mem_be_n(mem_be_n),
        .mem_bhe_n(mem_bhe_n), .mem_ble_n(mem_ble_n), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .size8_n(size8_n), .size16_n(size16_n), .rsp_rdata(rsp_rdata),
        .rsp_done(rsp_done)
    );

    // width, be_n, is_write, expected low address, expected bhe_n, ble_n
    typedef struct packed {
        logic [1:0] w;
        logic [3:0] be_n;
        logic       wr;
        logic [1:0] ea;
        logic       ebhe;
        logic       eble;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{2'd0, 4'b0000, 1'b0, 2'b00, 1'b1, 1'b1},
        '{2'd0, 4'b0111, 1'b1, 2'b00, 1'b1, 1'b1},
        '{2'd1, 4'b1110, 1'b0, 2'b00, 1'b1, 1'b0},
        '{2'd1, 4'b1100, 1'b1, 2'b00, 1'b0, 1'b0},
        '{2'd1, 4'b1101, 1'b0, 2'b01, 1'b0, 1'b1},
        '{2'd1, 4'b0011, 1'b1, 2'b10, 1'b0, 1'b0},
        '{2'd1, 4'b0111, 1'b0, 2'b11, 1'b0, 1'b1},
        '{2'd1, 4'b1011, 1'b1, 2'b10, 1'b1, 1'b0},
        '{2'd1, 4'b0110, 1'b0, 2'b00, 1'b1, 1'b0},
        '{2'd2, 4'b1110, 1'b1, 2'b00, 1'b1, 1'b0},
        '{2'd2, 4'b1101, 1'b0, 2'b01, 1'b1, 1'b1},
        '{2'd2, 4'b1011, 1'b1, 2'b10, 1'b1, 1'b0},
        '{2'd2, 4'b0111, 1'b0, 2'b11, 1'b1, 1'b1},
        '{2'd2, 4'b0000, 1'b1, 2'b00, 1'b1, 1'b0},
        '{2'd2, 4'b1001, 1'b0, 2'b01, 1'b1, 1'b1},
        '{2'd3, 4'b1010, 1'b1, 2'b00, 1'b1, 1'b1}
    };

    // Values seen at the ports during one access.
    logic [31:0] c_addr, c_wdata, c_rsp;
    logic [3:0]  c_be;
    logic        c_bhe, c_ble, c_rd, c_wr, c_s8, c_s16, c_done, c_done2, c_rd2, c_wr2;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request, then sample the memory cycle and the completion.
    task automatic access(input logic [1:0] w, input logic [3:0] be, input logic rd,
                          input logic wr, input logic [29:0] wa, input logic [31:0] wd,
                          input logic [31:0] md);
        @(negedge clk);
        region_width = w; req_be_n = be; req_rd = rd; req_wr = wr;
        req_addr = wa; req_wdata = wd;
        @(negedge clk);
        req_rd = 1'b0; req_wr = 1'b0;
        c_addr = mem_addr; c_be = mem_be_n; c_bhe = mem_bhe_n; c_ble = mem_ble_n;
        c_rd = mem_rd; c_wr = mem_wr; c_s8 = size8_n; c_s16 = size16_n;
        c_wdata = mem_wdata;
        mem_rdata = md;
        @(negedge clk);
        c_done = rsp_done; c_rsp = rsp_rdata; c_rd2 = mem_rd; c_wr2 = mem_wr;
        @(negedge clk);
        c_done2 = rsp_done;
    endtask

    function automatic int low_byte(input logic [3:0] be_n);
        for (int i = 3; i >= 0; i--) if (!be_n[i]) low_byte = i;
        if (be_n == 4'hF) low_byte = 0;
    endfunction

    function automatic logic [31:0] exp_wr(input logic [1:0] w, input int idx, input logic [31:0] wd);
        exp_wr = wd;
        if (w == 2'd1) exp_wr[15:0] = (idx >= 2) ? wd[31:16] : wd[15:0];
        if (w == 2'd2) exp_wr[7:0] = wd[8*idx +: 8];
    endfunction

    function automatic logic [31:0] exp_rd(input logic [1:0] w, input logic [31:0] md);
        if (w == 2'd1)      exp_rd = {md[15:0], md[15:0]};
        else if (w == 2'd2) exp_rd = {4{md[7:0]}};
        else                exp_rd = md;
    endfunction

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: idle state after reset
        check("R11 reset mem_rd", {31'd0, mem_rd}, 32'd0);
        check("R11 reset mem_wr", {31'd0, mem_wr}, 32'd0);
        check("R11 reset done", {31'd0, rsp_done}, 32'd0);
        check("R11 reset sizes", {30'd0, size8_n, size16_n}, 32'd3);
        check("R11 reset enables", {26'd0, mem_be_n, mem_bhe_n, mem_ble_n}, 32'h3F);
        check("R11 reset addr", mem_addr, 32'd0);
        check("R11 reset rdata", rsp_rdata, 32'd0);
        rst_n = 1'b1;

        // Table walk covering R1..R9
        for (int i = 0; i < 16; i++) begin
            vec_t v = VECS[i];
            logic [29:0] wa = 30'h0123_4560 + 30'(i);
            logic [31:0] wd = 32'h8877_6655 + 32'(i) * 32'h0101_0101;
            logic [31:0] md = 32'hF0E1_D2C3 ^ {4{8'(i)}};
            logic narrow = (v.w == 2'd1) || (v.w == 2'd2);
            access(v.w, v.be_n, !v.wr, v.wr, wa, wd, md);
            check($sformatf("R2 R4 R5 addr v%0d", i), c_addr, {wa, v.ea});
            check($sformatf("R6 bhe v%0d", i), {31'd0, c_bhe}, {31'd0, v.ebhe});
            check($sformatf("R5 ble v%0d", i), {31'd0, c_ble}, {31'd0, v.eble});
            check($sformatf("R2 R5 be v%0d", i), {28'd0, c_be}, {28'd0, narrow ? 4'hF : v.be_n});
            check($sformatf("R3 sizes v%0d", i), {30'd0, c_s8, c_s16},
                  {30'd0, v.w != 2'd2, v.w != 2'd1});
            check($sformatf("R1 strobes v%0d", i), {30'd0, c_rd, c_wr}, {30'd0, !v.wr, v.wr});
            check($sformatf("R1 strobe one cycle v%0d", i), {30'd0, c_rd2, c_wr2}, 32'd0);
            check($sformatf("R9 done v%0d", i), {30'd0, c_done, c_done2}, 32'd2);
            if (v.wr)
                check($sformatf("R7 R8 wdata v%0d", i), c_wdata,
                      exp_wr(v.w, low_byte(v.be_n), wd));
            else
                check($sformatf("R9 rdata v%0d", i), c_rsp, exp_rd(v.w, md));
        end

        // R1: read wins when both strobes are high
        access(2'd0, 4'b0000, 1'b1, 1'b1, 30'h11, 32'hDEAD_BEEF, 32'h1357_9BDF);
        check("R1 both strobes read wins", {30'd0, c_rd, c_wr}, 32'd2);
        check("R9 read result", c_rsp, 32'h1357_9BDF);

        // Known write data before the no-op write
        access(2'd0, 4'b0000, 1'b0, 1'b1, 30'h12, 32'hCAFE_F00D, 32'h0);
        check("R2 write passthrough", c_wdata, 32'hCAFE_F00D);

        // R10: no-op read on an 8-bit region
        access(2'd2, 4'b1111, 1'b1, 1'b0, 30'h13, 32'h0, 32'h2468_ACE0);
        check("R10 noop read strobes", {30'd0, c_rd, c_wr}, 32'd0);
        check("R10 noop read done", {30'd0, c_done, c_done2}, 32'd2);
        check("R10 noop read rdata held", c_rsp, 32'h1357_9BDF);
        check("R3 noop size8", {30'd0, c_s8, c_s16}, 32'd1);

        // R10: no-op write on a 16-bit region
        access(2'd1, 4'b1111, 1'b0, 1'b1, 30'h14, 32'h5555_AAAA, 32'h0);
        check("R10 noop write strobes", {30'd0, c_rd, c_wr}, 32'd0);
        check("R10 noop write data held", c_wdata, 32'hCAFE_F00D);
        check("R10 noop write done", {31'd0, c_done}, 32'd1);
        check("R10 noop enables", {30'd0, c_bhe, c_ble}, 32'd3);

        // R11: reset in the middle of a presented cycle
        @(negedge clk);
        region_width = 2'd2; req_be_n = 4'b1101; req_rd = 1'b1; req_addr = 30'h3F;
        @(negedge clk);
        req_rd = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R11 mid reset strobes", {29'd0, mem_rd, mem_wr, rsp_done}, 32'd0);
        check("R11 mid reset sizes", {30'd0, size8_n, size16_n}, 32'd3);
        check("R11 mid reset addr", mem_addr, 32'd0);
        check("R11 mid reset rdata", rsp_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule